// File: doc/BRIEF.md
# Parallel-Port Burst Transfer Engine

This block moves a programmed number of bytes between on-chip byte queues and an external device on an 8-bit multiplexed parallel bus. In the outbound direction it pops bytes from a source queue and presents each one on the bus with an active-low write qualifier and a data strobe. In the inbound direction it strobes the device and pushes the returned byte into a destination queue. Each byte completes when the device acknowledges by pulling its wait line low. A 16-bit down-counter, loaded one byte at a time, decides when the burst ends.

Firmware starts a burst by loading the length and setting one of two direction enables. Up to three device status pins can each be required to show a "ready" level before any cycle starts. One polarity bit gives the ready level for all three pins, and a mode bit says whether the test applies to outbound or to inbound cycles. An optional filter on the wait line rejects one-sample glitches at the cost of an extra cycle of latency. A falling edge on the device interrupt line raises a flag and drops both enables. While the sequencer is idle, a manual mode can drive a firmware byte onto the bus, and the live bus state can always be read back.

Top module: `ppBurstEngine`

## Requirements
- R1: After reset, dstrbN and writeN are high, adOe is low, enState is 0, remaining is 0 and intFlag is 0.
- R2: In an outbound cycle the byte popped from the source queue (popReq with popData, in queue order) is driven on adOut. writeN goes low at least one cycle before dstrbN goes low. adOe stays high for as long as writeN is low and for one cycle after both are released.
- R3: cfgByte with lenWrLo loads remaining[7:0], and with lenWrHi loads remaining[15:8]. remaining drops by exactly one per completed byte. done is a one-cycle pulse issued when it reaches zero. No cycle starts while it is zero.
- R4: In an inbound cycle adOe is low while dstrbN is low. The adIn value from the last strobe-low cycle is pushed (pushReq with pushData) in order.
- R5: The acknowledge is waitN low. The strobe stays low for REL_CYC cycles after the acknowledge is recognised. When waitN falls and then holds, dstrbN rises on the (REL_CYC+4)th rising edge with the filter off and on the (REL_CYC+5)th with it on.
- R6: With filtEn high, a waitN low pulse lasting one cycle is ignored and the strobe stays low. With filtEn low, the same pulse completes the cycle.
- R7: When chkEn[i] is set, stsPin[i] must equal chkPolHigh before a cycle starts. With chkOnWrite=1 the test gates outbound cycles only; with chkOnWrite=0 it gates inbound cycles only.
- R8: A falling edge on intN sets intFlag and clears both enables in the same cycle. A byte already in flight completes, and no further cycle starts. intClr clears intFlag.
- R9: No outbound cycle starts while srcEmpty is high, and no inbound cycle starts while dstFull is high. remaining is held meanwhile.
- R10: enIn bit 0 enables inbound cycles and bit 1 enables outbound cycles. When both are set and both can start, the inbound cycle goes first.
- R11: While the sequencer is idle and manOe is high, adOe is high and adOut equals manData. pinRead always equals adIn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| lenWrLo | input | 1 | Load cfgByte into length bits 7:0 |
| lenWrHi | input | 1 | Load cfgByte into length bits 15:8 |
| cfgByte | input | 8 | Length byte |
| enWr | input | 1 | Load enIn into the direction enables |
| enIn | input | 2 | Bit 0 inbound, bit 1 outbound |
| enState | output | 2 | Current direction enables |
| chkEn | input | 3 | Per-pin status test enables |
| chkPolHigh | input | 1 | Ready level of the status pins |
| chkOnWrite | input | 1 | 1: test gates outbound, 0: inbound |
| filtEn | input | 1 | Wait-line glitch filter enable |
| manOe | input | 1 | Manual bus drive enable |
| manData | input | 8 | Manual bus byte |
| pinRead | output | 8 | Live bus pin state |
| intFlag | output | 1 | Device interrupt seen |
| intClr | input | 1 | Clear intFlag |
| initReq | input | 1 | Request device initialisation |
| adOut | output | 8 | Bus output value |
| adOe | output | 1 | Bus output enable |
| adIn | input | 8 | Bus pin value |
| writeN | output | 1 | Active-low write qualifier |
| dstrbN | output | 1 | Active-low data strobe |
| astrbN | output | 1 | Active-low address strobe, parked high |
| initN | output | 1 | Active-low device init, registered |
| waitN | input | 1 | Active-low acknowledge |
| intN | input | 1 | Active-low device interrupt |
| stsPin | input | 3 | Device status pins |
| srcEmpty | input | 1 | Source queue empty |
| popReq | output | 1 | Pop one byte from source queue |
| popData | input | 8 | Head of source queue |
| dstFull | input | 1 | Destination queue full |
| pushReq | output | 1 | Push pushData into destination queue |
| pushData | output | 8 | Captured inbound byte |
| remaining | output | 16 | Bytes left in the burst |
| done | output | 1 | Burst complete pulse |

## Verification
The bench builds the engine with REL_CYC=3 and GAP_CYC=4, so each byte takes only about a dozen cycles. That leaves room for many randomised bursts in both directions in a short run. With this release window, the filtered and unfiltered acknowledge latencies differ by exactly one edge, and the bench measures that difference from the pins. The short gap also lets a single-cycle wait glitch land inside a strobe. Directed runs then cover stalls on the queue flags, status gating, priority between directions, and an interrupt that arrives mid-burst.

// File: rtl/ppb_pkg.sv
package ppb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STRB,
    ST_REL,
    ST_HOLD,
    ST_GAP
  } seqState_t;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic popByte;
    logic capByte;
    logic decLen;
    logic driveBus;
    logic drvWrite;
    logic drvStrobe;
  } seqCmd_t;

endpackage

// File: rtl/ppbCtrl.sv
module ppbCtrl
  import ppb_pkg::*;
#(
  parameter int REL_CYC = 3,
  parameter int GAP_CYC = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ackNow,
  input  logic       stsOkRd,
  input  logic       stsOkWr,
  input  logic       lenZero,
  input  logic [1:0] enState,
  input  logic       srcEmpty,
  input  logic       dstFull,
  output seqCmd_t    cmd,
  output logic       seqIdle
);
  localparam int TMAX = (REL_CYC > GAP_CYC) ? REL_CYC : GAP_CYC;
  localparam int TW   = $clog2(TMAX + 1);

  seqState_t state;
  logic [TW-1:0] tmr;
  logic dirWr;
  logic goRd, goWr, relLast, gapDone;

  assign goRd    = enState[0] && !lenZero && !dstFull && stsOkRd;
  assign goWr    = enState[1] && !goRd && !lenZero && !srcEmpty && stsOkWr;
  assign relLast = (tmr == TW'(REL_CYC - 1));
  assign gapDone = (tmr >= TW'(GAP_CYC - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      tmr   <= '0;
      dirWr <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (goRd || goWr) begin
          dirWr <= goWr;
          state <= ST_SETUP;
        end
        ST_SETUP: state <= ST_STRB;
        ST_STRB: if (ackNow) begin
          state <= ST_REL;
          tmr   <= '0;
        end
        ST_REL: begin
          if (relLast) state <= ST_HOLD;
          else         tmr   <= tmr + 1'b1;
        end
        ST_HOLD: begin
          state <= ST_GAP;
          tmr   <= '0;
        end
        ST_GAP: begin
          if (gapDone && !ackNow) state <= ST_IDLE;
          else if (!gapDone)      tmr   <= tmr + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    cmd           = '0;
    cmd.popByte   = (state == ST_IDLE) && goWr;
    cmd.capByte   = (state == ST_REL) && relLast && !dirWr;
    cmd.decLen    = (state == ST_REL) && relLast;
    cmd.drvStrobe = (state == ST_STRB) || (state == ST_REL);
    cmd.drvWrite  = dirWr && ((state == ST_SETUP) || cmd.drvStrobe);
    cmd.driveBus  = dirWr && ((state == ST_SETUP) || cmd.drvStrobe || (state == ST_HOLD));
  end

  assign seqIdle = (state == ST_IDLE);

endmodule

// File: rtl/ppbDatapath.sv
module ppbDatapath
  import ppb_pkg::*;
#(
  parameter int LEN_W  = 16,
  parameter int DATA_W = 8,
  parameter int NSTS   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCmd_t           cmd,
  input  logic              seqIdle,
  input  logic              lenWrLo,
  input  logic              lenWrHi,
  input  logic [DATA_W-1:0] cfgByte,
  input  logic              enWr,
  input  logic [1:0]        enIn,
  input  logic [NSTS-1:0]   chkEn,
  input  logic              chkPolHigh,
  input  logic              chkOnWrite,
  input  logic              filtEn,
  input  logic              manOe,
  input  logic [DATA_W-1:0] manData,
  input  logic              intClr,
  input  logic              initReq,
  input  logic [DATA_W-1:0] adIn,
  input  logic              waitN,
  input  logic              intN,
  input  logic [NSTS-1:0]   stsPin,
  input  logic [DATA_W-1:0] popData,
  output logic              ackNow,
  output logic              stsOkRd,
  output logic              stsOkWr,
  output logic              lenZero,
  output logic [1:0]        enState,
  output logic              intFlag,
  output logic [DATA_W-1:0] adOut,
  output logic              adOe,
  output logic              writeN,
  output logic              dstrbN,
  output logic              initN,
  output logic              pushReq,
  output logic [DATA_W-1:0] pushData,
  output logic [LEN_W-1:0]  remaining,
  output logic              done
);
  localparam int HI_W = LEN_W - DATA_W;

  logic [NSTS-1:0] stsS1, stsS2, pinOk;
  logic waitS1, waitS2, waitP, waitQual;
  logic intS1, intS2, intS3, intFall;
  logic [LEN_W-1:0] lenReg;
  logic [DATA_W-1:0] dataReg;
  logic allOk;

  // input synchronisers and wait filter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stsS1 <= '0; stsS2 <= '0;
      waitS1 <= 1'b1; waitS2 <= 1'b1; waitP <= 1'b1; waitQual <= 1'b1;
      intS1 <= 1'b1; intS2 <= 1'b1; intS3 <= 1'b1;
    end else begin
      stsS1 <= stsPin; stsS2 <= stsS1;
      waitS1 <= waitN; waitS2 <= waitS1; waitP <= waitS2;
      if (!filtEn)              waitQual <= waitS2;
      else if (waitS2 == waitP) waitQual <= waitS2;
      intS1 <= intN; intS2 <= intS1; intS3 <= intS2;
    end
  end

  assign ackNow  = ~waitQual;
  assign intFall = intS3 & ~intS2;

  for (genvar i = 0; i < NSTS; i++) begin : g_sts
    assign pinOk[i] = ~chkEn[i] | (stsS2[i] == chkPolHigh);
  end
  assign allOk   = &pinOk;
  assign stsOkWr = chkOnWrite ? allOk : 1'b1;
  assign stsOkRd = chkOnWrite ? 1'b1 : allOk;

  // length counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lenReg <= '0;
      done   <= 1'b0;
    end else begin
      done <= cmd.decLen && (lenReg == LEN_W'(1));
      if (lenWrLo)                   lenReg[DATA_W-1:0]     <= cfgByte;
      else if (lenWrHi)              lenReg[LEN_W-1:DATA_W] <= cfgByte[HI_W-1:0];
      else if (cmd.decLen && !lenZero) lenReg <= lenReg - 1'b1;
    end
  end
  assign lenZero   = (lenReg == '0);
  assign remaining = lenReg;

  // direction enables and interrupt flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enState <= '0;
      intFlag <= 1'b0;
      initN   <= 1'b1;
    end else begin
      if (intFall)   enState <= '0;
      else if (enWr) enState <= enIn;
      if (intFall)     intFlag <= 1'b1;
      else if (intClr) intFlag <= 1'b0;
      initN <= ~initReq;
    end
  end

  // byte path
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg  <= '0;
      pushData <= '0;
      pushReq  <= 1'b0;
    end else begin
      if (cmd.popByte) dataReg <= popData;
      pushReq <= cmd.capByte;
      if (cmd.capByte) pushData <= adIn;
    end
  end

  assign adOe   = cmd.driveBus | (seqIdle & manOe);
  assign adOut  = seqIdle ? manData : dataReg;
  assign writeN = ~cmd.drvWrite;
  assign dstrbN = ~cmd.drvStrobe;

endmodule

// File: rtl/ppBurstEngine.sv
module ppBurstEngine
  import ppb_pkg::*;
#(
  parameter int LEN_W   = 16,
  parameter int DATA_W  = 8,
  parameter int NSTS    = 3,
  parameter int REL_CYC = 3,
  parameter int GAP_CYC = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lenWrLo,
  input  logic              lenWrHi,
  input  logic [DATA_W-1:0] cfgByte,
  input  logic              enWr,
  input  logic [1:0]        enIn,
  output logic [1:0]        enState,
  input  logic [NSTS-1:0]   chkEn,
  input  logic              chkPolHigh,
  input  logic              chkOnWrite,
  input  logic              filtEn,
  input  logic              manOe,
  input  logic [DATA_W-1:0] manData,
  output logic [DATA_W-1:0] pinRead,
  output logic              intFlag,
  input  logic              intClr,
  input  logic              initReq,
  output logic [DATA_W-1:0] adOut,
  output logic              adOe,
  input  logic [DATA_W-1:0] adIn,
  output logic              writeN,
  output logic              dstrbN,
  output logic              astrbN,
  output logic              initN,
  input  logic              waitN,
  input  logic              intN,
  input  logic [NSTS-1:0]   stsPin,
  input  logic              srcEmpty,
  output logic              popReq,
  input  logic [DATA_W-1:0] popData,
  input  logic              dstFull,
  output logic              pushReq,
  output logic [DATA_W-1:0] pushData,
  output logic [LEN_W-1:0]  remaining,
  output logic              done
);
  seqCmd_t cmd;
  logic seqIdle, ackNow, stsOkRd, stsOkWr, lenZero;

  ppbCtrl #(.REL_CYC(REL_CYC), .GAP_CYC(GAP_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .ackNow(ackNow), .stsOkRd(stsOkRd),
    .stsOkWr(stsOkWr), .lenZero(lenZero), .enState(enState),
    .srcEmpty(srcEmpty), .dstFull(dstFull), .cmd(cmd), .seqIdle(seqIdle)
  );

  ppbDatapath #(.LEN_W(LEN_W), .DATA_W(DATA_W), .NSTS(NSTS)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .seqIdle(seqIdle),
    .lenWrLo(lenWrLo), .lenWrHi(lenWrHi), .cfgByte(cfgByte),
    .enWr(enWr), .enIn(enIn), .chkEn(chkEn), .chkPolHigh(chkPolHigh),
    .chkOnWrite(chkOnWrite), .filtEn(filtEn), .manOe(manOe),
    .manData(manData), .intClr(intClr), .initReq(initReq), .adIn(adIn),
    .waitN(waitN), .intN(intN), .stsPin(stsPin), .popData(popData),
    .ackNow(ackNow), .stsOkRd(stsOkRd), .stsOkWr(stsOkWr),
    .lenZero(lenZero), .enState(enState), .intFlag(intFlag),
    .adOut(adOut), .adOe(adOe), .writeN(writeN), .dstrbN(dstrbN),
    .initN(initN), .pushReq(pushReq), .pushData(pushData),
    .remaining(remaining), .done(done)
  );

  assign popReq  = cmd.popByte;
  assign pinRead = adIn;
  assign astrbN  = 1'b1;

endmodule

// File: rtl/ppBurstEngine_chk.sv
module ppBurstEngine_chk #(
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             writeN,
  input logic             dstrbN,
  input logic             adOe,
  input logic             done,
  input logic [LEN_W-1:0] remaining,
  input logic             lenWrLo,
  input logic             lenWrHi,
  input logic             popReq,
  input logic             srcEmpty,
  input logic             intFlag,
  input logic [1:0]       enState
);
  // R2
  wr_drives_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    !writeN |-> adOe);
  // R2
  wr_before_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(dstrbN) && !writeN) |-> $past(!writeN));
  // R4
  rd_bus_released_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!dstrbN && writeN) |-> !adOe);
  // R3
  done_at_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (remaining == '0));
  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((remaining != $past(remaining)) && !$past(lenWrLo) && !$past(lenWrHi))
      |-> (remaining == $past(remaining) - 1'b1));
  // R9
  pop_not_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    popReq |-> !srcEmpty);
  // R8
  int_clears_en_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intFlag) |-> (enState == 2'b00));
endmodule

bind ppBurstEngine ppBurstEngine_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rstN(rstN), .writeN(writeN), .dstrbN(dstrbN), .adOe(adOe),
  .done(done), .remaining(remaining), .lenWrLo(lenWrLo), .lenWrHi(lenWrHi),
  .popReq(popReq), .srcEmpty(srcEmpty), .intFlag(intFlag), .enState(enState)
);

// File: tb/ppBurstEngine_bench.sv
module ppBurstEngine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int REL = 3;
  localparam int GAP = 4;

  logic clk = 0, rstN = 0;
  logic lenWrLo = 0, lenWrHi = 0, enWr = 0, chkPolHigh = 1, chkOnWrite = 0;
  logic filtEn = 0, manOe = 0, intClr = 0, initReq = 0, intN = 1, dstFull = 0;
  logic [7:0] cfgByte = 0, manData = 0;
  logic [1:0] enIn = 0;
  logic [2:0] chkEn = 0, stsPin = 0;
  logic [1:0] enState;
  logic [7:0] pinRead, adOut, adIn, popData, pushData;
  logic intFlag, adOe, writeN, dstrbN, astrbN, initN, popReq, pushReq, done;
  logic [15:0] remaining;
  logic waitN, srcEmpty;

  // bench models
  logic devAuto = 1, waitAuto = 1, waitMan = 1;
  logic [7:0] srcMem [256];
  logic [7:0] devMem [256];
  logic [7:0] devRx  [256];
  logic [7:0] pushMem[256];
  logic [15:0] srcWr = 0, srcRd = 0, devIdx = 0, devRxCnt = 0, pushCnt = 0;
  logic [15:0] strobeCnt = 0, doneCnt = 0;
  logic [2:0] ackCnt = 0;
  logic strbPrev = 1, wasWr = 0;
  int nChecks = 0, nFail = 0;

  assign waitN    = devAuto ? waitAuto : waitMan;
  assign srcEmpty = (srcWr == srcRd);
  assign popData  = srcMem[srcRd[7:0]];
  assign adIn     = adOe ? adOut : devMem[devIdx[7:0]];

  ppBurstEngine u_ppBurstEngine (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (popReq) srcRd <= srcRd + 1;
    if (pushReq) begin pushMem[pushCnt[7:0]] <= pushData; pushCnt <= pushCnt + 1; end
    if (done) doneCnt <= doneCnt + 1;
    strbPrev <= dstrbN;
    if (!dstrbN) wasWr <= !writeN;
    if (strbPrev && !dstrbN) strobeCnt <= strobeCnt + 1;
    if (!strbPrev && dstrbN) begin
      if (wasWr) begin devRx[devRxCnt[7:0]] <= adOut; devRxCnt <= devRxCnt + 1; end
      else devIdx <= devIdx + 1;
    end
    if (!dstrbN) begin
      if (ackCnt == 3'd2) waitAuto <= 1'b0; else ackCnt <= ackCnt + 1;
    end else begin
      waitAuto <= 1'b1; ackCnt <= 0;
    end
  end

  function automatic int expLatency(input logic filt);
    return REL + 4 + (filt ? 1 : 0);
  endfunction

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setLen(input logic [15:0] v);
    @(negedge clk); cfgByte = v[7:0]; lenWrLo = 1;
    @(negedge clk); lenWrLo = 0; cfgByte = v[15:8]; lenWrHi = 1;
    @(negedge clk); lenWrHi = 0;
  endtask

  task automatic setEn(input logic [1:0] v);
    @(negedge clk); enIn = v; enWr = 1;
    @(negedge clk); enWr = 0;
  endtask

  task automatic waitDone(input logic [15:0] d0);
    int t = 0;
    while (doneCnt == d0 && t < 3000) begin @(negedge clk); t++; end
    cyc(GAP + 4);
  endtask

  task automatic waitStrobe();
    int t = 0;
    while (dstrbN && t < 200) begin @(negedge clk); t++; end
  endtask

  task automatic measure(output int n);
    n = 0;
    while (dstrbN == 0 && n < 20) begin @(posedge clk); #1; n++; end
  endtask

  initial begin
    int n;
    logic [15:0] d0, b0, s0;
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) devMem[i] = 8'($urandom);
    cyc(5); rstN = 1; cyc(2);

    // R1 reset state
    check(dstrbN && writeN && !adOe, "R1 strobes idle", {dstrbN, writeN, adOe}, 3'b110);
    check(enState == 0 && remaining == 0 && !intFlag, "R1 regs cleared", remaining, 0);

    // R3 length load
    setLen(16'h0102);
    check(remaining == 16'd258, "R3 length bytes", remaining, 258);
    setLen(16'h0000);

    // R11 manual drive and pin readback
    @(negedge clk); manOe = 1; manData = 8'hA5;
    @(negedge clk);
    check(adOe && adOut == 8'hA5, "R11 manual drive", adOut, 8'hA5);
    manOe = 0; @(negedge clk);
    check(pinRead == devMem[devIdx[7:0]], "R11 pin readback", pinRead, devMem[devIdx[7:0]]);

    // R2/R3 random outbound bursts
    for (int k = 0; k < 4; k++) begin
      int len = 1 + ($urandom % 12);
      b0 = devRxCnt; d0 = doneCnt;
      for (int j = 0; j < len; j++) begin srcMem[srcWr[7:0]] = 8'($urandom); srcWr = srcWr + 1; end
      setLen(16'(len)); setEn(2'b10); waitDone(d0);
      check(doneCnt == d0 + 1, "R3 one done pulse", doneCnt - d0, 1);
      check(remaining == 0, "R3 count reaches zero", remaining, 0);
      check(devRxCnt - b0 == 16'(len), "R2 byte count", devRxCnt - b0, len);
      for (int j = 0; j < len; j++)
        check(devRx[8'(b0 + j)] == srcMem[8'(srcWr - len + j)], "R2 byte order",
              devRx[8'(b0 + j)], srcMem[8'(srcWr - len + j)]);
    end

    // R4 random inbound bursts
    setEn(2'b01);
    for (int k = 0; k < 4; k++) begin
      int len = 1 + ($urandom % 12);
      b0 = pushCnt; s0 = devIdx; d0 = doneCnt;
      setLen(16'(len)); waitDone(d0);
      check(pushCnt - b0 == 16'(len), "R4 push count", pushCnt - b0, len);
      for (int j = 0; j < len; j++)
        check(pushMem[8'(b0 + j)] == devMem[8'(s0 + j)], "R4 byte order",
              pushMem[8'(b0 + j)], devMem[8'(s0 + j)]);
    end

    // R9 stall on empty source / full destination
    setEn(2'b10); s0 = strobeCnt; setLen(16'd3); cyc(30);
    check(strobeCnt == s0 && remaining == 3, "R9 empty source stalls", remaining, 3);
    for (int j = 0; j < 3; j++) begin srcMem[srcWr[7:0]] = 8'($urandom); srcWr = srcWr + 1; end
    d0 = doneCnt; waitDone(d0);
    check(remaining == 0, "R9 resumes after fill", remaining, 0);
    dstFull = 1; setEn(2'b01); s0 = strobeCnt; setLen(16'd2); cyc(30);
    check(strobeCnt == s0 && remaining == 2, "R9 full destination stalls", remaining, 2);
    d0 = doneCnt; dstFull = 0; waitDone(d0);
    check(remaining == 0, "R9 inbound resumes", remaining, 0);

    // R7 status gating of inbound only
    chkEn = 3'b001; chkPolHigh = 1; chkOnWrite = 0; stsPin = 3'b000;
    s0 = strobeCnt; setLen(16'd2); cyc(30);
    check(strobeCnt == s0, "R7 inbound held by status", strobeCnt - s0, 0);
    setEn(2'b10); srcMem[srcWr[7:0]] = 8'h5A; srcWr = srcWr + 1;
    d0 = doneCnt; setLen(16'd1); waitDone(d0);
    check(remaining == 0, "R7 outbound not gated", remaining, 0);
    stsPin = 3'b001; setEn(2'b01); d0 = doneCnt; setLen(16'd2); waitDone(d0);
    check(remaining == 0, "R7 inbound after ready", remaining, 0);
    chkEn = 0;

    // R10 inbound priority
    srcMem[srcWr[7:0]] = 8'h77; srcWr = srcWr + 1;
    setEn(2'b11); setLen(16'd1); waitStrobe();
    check(writeN == 1, "R10 inbound first", writeN, 1);
    d0 = doneCnt; waitDone(d0); setEn(2'b00); setLen(16'd0);
    srcRd = srcRd; // source byte left queued

    // R5/R6 wait filter and release latency
    devAuto = 0; waitMan = 1; filtEn = 1; cyc(4);
    setEn(2'b10); setLen(16'd2); waitStrobe();
    @(negedge clk); waitMan = 0; @(negedge clk); waitMan = 1; cyc(8);
    check(dstrbN == 0, "R6 filtered glitch ignored", dstrbN, 0);
    @(negedge clk); waitMan = 0; measure(n);
    check(n == expLatency(1), "R5 filtered latency", n, expLatency(1));
    @(negedge clk); waitMan = 1;
    filtEn = 0; srcMem[srcWr[7:0]] = 8'h33; srcWr = srcWr + 1;
    waitStrobe();
    @(negedge clk); waitMan = 0; @(negedge clk); waitMan = 1; cyc(8);
    check(dstrbN == 1, "R6 unfiltered glitch acts", dstrbN, 1);
    cyc(10);
    srcMem[srcWr[7:0]] = 8'h44; srcWr = srcWr + 1;
    setLen(16'd1); waitStrobe();
    @(negedge clk); waitMan = 0; measure(n);
    check(n == expLatency(0), "R5 unfiltered latency", n, expLatency(0));
    @(negedge clk); waitMan = 1; devAuto = 1; cyc(12);

    // R8 interrupt aborts burst
    setEn(2'b01); setLen(16'd40); cyc(40);
    @(negedge clk); intN = 0; cyc(30);
    check(enState == 0 && intFlag, "R8 flag set enables cleared", enState, 0);
    s0 = remaining; cyc(30);
    check(remaining == s0 && remaining != 0, "R8 no further cycles", remaining, s0);
    @(negedge clk); intN = 1; intClr = 1; @(negedge clk); intClr = 0; @(negedge clk);
    check(!intFlag, "R8 flag cleared", intFlag, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    nFail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule